// File: doc/BRIEF.md
# Multi-mode microcontroller expansion port

This block is one parallel I/O port mapped into a microcontroller's address space. A small synchronous register bus gives software four locations: sampled pin levels, a per-pin mode-select register, an output value register and a per-pin drive register. With these, each pin can act in one of three ways. It can be a general-purpose pin that software drives or reads. It can carry a logic-array output whose drive is gated by a product term. It can present a bit of an address bus.

Two external controls override the per-pin choice. A peripheral-pass bit hands every pin to a peripheral data path. A test-access enable releases a fixed, parameter-chosen group of pins so that a debug controller can own them. Tri-state pins appear as a value output and a separate drive-enable output per bit. Pin inputs go through a synchronizer before software can read them. A build option removes the mode-select register, which leaves a port that only works as general-purpose I/O.

Top module: `mcu_xp_port`

## Requirements
- R1: While reset is held and after it is released, the mode-select, output-value and drive registers hold 0. With no enable term active, every pin has pin_oe = 0.
- R2: A pin whose mode-select bit is 0 shows its output-value register bit on pin_out.
- R3: A pin whose mode-select bit is 0 has pin_oe equal to its drive bit ORed with its pla_oe bit. A drive bit of 1 means output and 0 means input.
- R4: Register offset 0 returns pin_in through a two-flop synchronizer. A read strobed one cycle after a pin change still returns the old level. A read strobed two cycles after the change returns the new level.
- R5: Offsets 1, 2 and 3 read back the mode-select, output-value and drive registers. Read data appears on bus_rdata in the cycle after the strobe. A write to offset 0 changes no register.
- R6: A pin whose mode-select bit and drive bit are both 1 outputs addr_in for that bit and has pin_oe = 1.
- R7: A pin whose mode-select bit is 1 and drive bit is 0 outputs pla_out for that bit, with pin_oe equal to its pla_oe bit.
- R8: When periph_en is 1, every pin that the test-access enable has not released outputs periph_out with pin_oe = periph_oe, whatever its mode-select and drive bits are.
- R9: When jtag_en is 1, the pins set in JTAG_MASK have pin_out = 0 and pin_oe = 0, ahead of every other mode. The other pins are unaffected.
- R10: With HAS_CTRL = 0, offset 1 reads 0, writes to it are ignored, and every pin behaves as in R2/R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Register bus select |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, one cycle after the strobe |
| pla_out | input | WIDTH | Logic-array output value per pin |
| pla_oe | input | WIDTH | Logic-array enable term per pin |
| addr_in | input | WIDTH | Address bits for address-out pins |
| periph_en | input | 1 | Peripheral-pass override |
| periph_out | input | WIDTH | Peripheral output value per pin |
| periph_oe | input | WIDTH | Peripheral drive enable per pin |
| jtag_en | input | 1 | Releases the JTAG_MASK pins |
| pin_in | input | WIDTH | Pin levels |
| pin_out | output | WIDTH | Pin output values |
| pin_oe | output | WIDTH | Pin drive enables |

## Verification
The bench builds two copies of the port with WIDTH = 8 and JTAG_MASK = 8'hF0. One has HAS_CTRL = 1 and the other HAS_CTRL = 0. Both share the same bus and pin stimulus. The mode-select settings place address-out pins and logic-array pins side by side, so every selection branch can be observed in a single pin vector. The control-less copy shows, on the same cycle, that mode writes have no effect on it. The split mask lets one vector show both released pins and pins that are still under port control.

// File: rtl/mxp_pkg.sv
package mxp_pkg;
    typedef enum logic [1:0] {
        OFS_PINS = 2'd0,
        OFS_MODE = 2'd1,
        OFS_OVAL = 2'd2,
        OFS_DRV  = 2'd3
    } ofs_e;
endpackage

// File: rtl/mxp_sync.sv
module mxp_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = d;
        for (int s = 1; s < STAGES; s++) begin
            sh_d[s] = sh_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign q = sh_q[LAST];

    generate
        if (STAGES > 1) begin : g_chk
            // R4
            sync_shift_chk: assert property (@(posedge clk) disable iff (rst)
                (!rst) |=> (sh_q[LAST] == $past(sh_q[LAST-1])));
        end
    endgenerate
endmodule

// File: rtl/mxp_regs.sv
module mxp_regs #(
    parameter int WIDTH    = 8,
    parameter bit HAS_CTRL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs,
    input  logic [1:0]       addr,
    input  logic             wr,
    input  logic             rd,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] pins_sync,
    output logic [WIDTH-1:0] mode,
    output logic [WIDTH-1:0] oval,
    output logic [WIDTH-1:0] drv,
    output logic [WIDTH-1:0] rdata
);
    import mxp_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] mode;
        logic [WIDTH-1:0] oval;
        logic [WIDTH-1:0] drv;
        logic [WIDTH-1:0] rdata;
    } regs_t;

    regs_t st_d, st_q;
    ofs_e  ofs;
    logic  wr_hit;
    logic  mode_we;

    assign ofs    = ofs_e'(addr);
    assign wr_hit = cs && wr;

    generate
        if (HAS_CTRL) begin : g_mode
            assign mode_we = wr_hit && (ofs == OFS_MODE);
        end else begin : g_nomode
            assign mode_we = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (mode_we) st_d.mode = wdata;
        if (wr_hit && ofs == OFS_OVAL) st_d.oval = wdata;
        if (wr_hit && ofs == OFS_DRV)  st_d.drv  = wdata;
        if (cs && rd) begin
            case (ofs)
                OFS_PINS: st_d.rdata = pins_sync;
                OFS_MODE: st_d.rdata = st_q.mode;
                OFS_OVAL: st_d.rdata = st_q.oval;
                default:  st_d.rdata = st_q.drv;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign mode  = st_q.mode;
    assign oval  = st_q.oval;
    assign drv   = st_q.drv;
    assign rdata = st_q.rdata;

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (st_q.mode == '0 && st_q.oval == '0 && st_q.drv == '0));

    // R5
    drv_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && wr && addr == 2'd3) |=> (drv == $past(wdata)));

    // R5
    oval_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && rd && addr == 2'd2) |=> (rdata == $past(oval)));
endmodule

// File: rtl/mxp_pinmux.sv
module mxp_pinmux #(
    parameter int               WIDTH     = 8,
    parameter logic [WIDTH-1:0] JTAG_MASK = '0
) (
    input  logic [WIDTH-1:0] mode,
    input  logic [WIDTH-1:0] oval,
    input  logic [WIDTH-1:0] drv,
    input  logic [WIDTH-1:0] pla_out,
    input  logic [WIDTH-1:0] pla_oe,
    input  logic [WIDTH-1:0] addr_in,
    input  logic             periph_en,
    input  logic [WIDTH-1:0] periph_out,
    input  logic [WIDTH-1:0] periph_oe,
    input  logic             jtag_en,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            always_comb begin
                if (jtag_en && JTAG_MASK[i]) begin
                    pin_out[i] = 1'b0;
                    pin_oe[i]  = 1'b0;
                end else if (periph_en) begin
                    pin_out[i] = periph_out[i];
                    pin_oe[i]  = periph_oe[i];
                end else if (mode[i] && drv[i]) begin
                    pin_out[i] = addr_in[i];
                    pin_oe[i]  = 1'b1;
                end else if (mode[i]) begin
                    pin_out[i] = pla_out[i];
                    pin_oe[i]  = pla_oe[i];
                end else begin
                    pin_out[i] = oval[i];
                    pin_oe[i]  = drv[i] | pla_oe[i];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/mcu_xp_port.sv
module mcu_xp_port #(
    parameter int               WIDTH     = 8,
    parameter bit               HAS_CTRL  = 1'b1,
    parameter logic [WIDTH-1:0] JTAG_MASK = 8'hF0,
    parameter int               SYNC_STG  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_cs,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pla_out,
    input  logic [WIDTH-1:0] pla_oe,
    input  logic [WIDTH-1:0] addr_in,
    input  logic             periph_en,
    input  logic [WIDTH-1:0] periph_out,
    input  logic [WIDTH-1:0] periph_oe,
    input  logic             jtag_en,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);
    logic [WIDTH-1:0] pins_sync;
    logic [WIDTH-1:0] mode, oval, drv;

    mxp_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(pins_sync)
    );

    mxp_regs #(.WIDTH(WIDTH), .HAS_CTRL(HAS_CTRL)) u_regs (
        .clk(clk), .rst(rst), .cs(bus_cs), .addr(bus_addr), .wr(bus_wr),
        .rd(bus_rd), .wdata(bus_wdata), .pins_sync(pins_sync),
        .mode(mode), .oval(oval), .drv(drv), .rdata(bus_rdata)
    );

    mxp_pinmux #(.WIDTH(WIDTH), .JTAG_MASK(JTAG_MASK)) u_mux (
        .mode(mode), .oval(oval), .drv(drv), .pla_out(pla_out),
        .pla_oe(pla_oe), .addr_in(addr_in), .periph_en(periph_en),
        .periph_out(periph_out), .periph_oe(periph_oe), .jtag_en(jtag_en),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // R9
    jtag_release_chk: assert property (@(posedge clk) disable iff (rst)
        jtag_en |-> ((pin_oe & JTAG_MASK) == '0 && (pin_out & JTAG_MASK) == '0));

    // R8
    periph_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (periph_en && !jtag_en) |-> (pin_oe == periph_oe && pin_out == periph_out));

    // R3
    gpio_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (!periph_en && !jtag_en && mode == '0) |-> (pin_oe == (drv | pla_oe)));

    // R10
    no_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (!HAS_CTRL) |-> (mode == '0));
endmodule

// File: tb/mcu_xp_port_tb.sv
module mcu_xp_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_cs = 0, bus_wr = 0, bus_rd = 0;
    logic [1:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] pla_out = '0, pla_oe = '0, addr_in = '0;
    logic         periph_en = 0, jtag_en = 0;
    logic [W-1:0] periph_out = '0, periph_oe = '0, pin_in = '0;
    logic [W-1:0] rdata, rdata_nc, pout, poe, pout_nc, poe_nc;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;
    logic took_rd = 1'b0;

    logic [W-1:0] exp_q[$];
    logic [W-1:0] expnc_q[$];
    string        tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mcu_xp_port #(.WIDTH(W), .HAS_CTRL(1'b1), .JTAG_MASK(8'hF0)) u_dut (
        .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(rdata), .pla_out(pla_out), .pla_oe(pla_oe),
        .addr_in(addr_in), .periph_en(periph_en), .periph_out(periph_out),
        .periph_oe(periph_oe), .jtag_en(jtag_en), .pin_in(pin_in),
        .pin_out(pout), .pin_oe(poe)
    );

    mcu_xp_port #(.WIDTH(W), .HAS_CTRL(1'b0), .JTAG_MASK(8'hF0)) u_dut_nc (
        .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_nc), .pla_out(pla_out), .pla_oe(pla_oe),
        .addr_in(addr_in), .periph_en(periph_en), .periph_out(periph_out),
        .periph_oe(periph_oe), .jtag_en(jtag_en), .pin_in(pin_in),
        .pin_out(pout_nc), .pin_oe(poe_nc)
    );

    // monitor: a read strobed at an edge shows its data before the next edge
    always @(posedge clk) took_rd <= bus_cs && bus_rd;

    always @(negedge clk) begin
        if (took_rd && exp_q.size() > 0) begin
            logic [W-1:0] e, enc;
            string t;
            e = exp_q.pop_front();
            enc = expnc_q.pop_front();
            t = tag_q.pop_front();
            vectors += 2;
            if (rdata !== e) begin
                errors++;
                $display("FAIL %s rdata actual=%h expected=%h", t, rdata, e);
            end
            if (rdata_nc !== enc) begin
                errors++;
                $display("FAIL %s rdata(no-ctrl) actual=%h expected=%h", t, rdata_nc, enc);
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_cs = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic [W-1:0] e,
                            input logic [W-1:0] enc, input string t);
        @(negedge clk);
        bus_cs = 1; bus_rd = 1; bus_addr = a;
        exp_q.push_back(e); expnc_q.push_back(enc); tag_q.push_back(t);
        @(negedge clk);
        bus_cs = 0; bus_rd = 0;
    endtask

    task automatic chk_pins(input string t, input logic [W-1:0] eo, input logic [W-1:0] ee,
                            input logic [W-1:0] eonc, input logic [W-1:0] eenc);
        vectors += 2;
        if (pout !== eo || poe !== ee) begin
            errors++;
            $display("FAIL %s pins actual out=%h oe=%h expected out=%h oe=%h", t, pout, poe, eo, ee);
        end
        if (pout_nc !== eonc || poe_nc !== eenc) begin
            errors++;
            $display("FAIL %s pins(no-ctrl) actual out=%h oe=%h expected out=%h oe=%h",
                     t, pout_nc, poe_nc, eonc, eenc);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_pins("R1 in reset", 8'h00, 8'h00, 8'h00, 8'h00);
        rst = 0;
        @(negedge clk);
        chk_pins("R1 after reset", 8'h00, 8'h00, 8'h00, 8'h00);
        bus_read(2'd1, 8'h00, 8'h00, "R1 mode");
        bus_read(2'd2, 8'h00, 8'h00, "R1 oval");
        bus_read(2'd3, 8'h00, 8'h00, "R1 drv");

        // general-purpose mode
        bus_write(2'd2, 8'hA5);
        bus_write(2'd3, 8'h0F);
        chk_pins("R2 R3 gpio drive", 8'hA5, 8'h0F, 8'hA5, 8'h0F);
        pla_oe = 8'h30;
        @(negedge clk);
        chk_pins("R3 or with pla_oe", 8'hA5, 8'h3F, 8'hA5, 8'h3F);

        // readback and read-only offset
        bus_write(2'd0, 8'h5A);
        bus_read(2'd2, 8'hA5, 8'hA5, "R5 oval readback");
        bus_read(2'd3, 8'h0F, 8'h0F, "R5 drv readback");
        bus_read(2'd1, 8'h00, 8'h00, "R5 mode after offset0 write");

        // synchronizer latency
        @(negedge clk); pin_in = 8'hC3;
        repeat (3) @(negedge clk);
        bus_read(2'd0, 8'hC3, 8'hC3, "R4 settled");
        pin_in = 8'h3C;
        bus_read(2'd0, 8'hC3, 8'hC3, "R4 one cycle old");
        bus_read(2'd0, 8'h3C, 8'h3C, "R4 two cycles new");

        // address-out and logic-array modes
        addr_in = 8'h96; pla_out = 8'hE1;
        bus_write(2'd1, 8'hFF);
        chk_pins("R6 R7 mixed", 8'hE6, 8'h3F, 8'hA5, 8'h3F);
        bus_read(2'd1, 8'hFF, 8'h00, "R10 mode readback");
        pla_oe = 8'hC0;
        @(negedge clk);
        chk_pins("R7 pla enable", 8'hE6, 8'hCF, 8'hA5, 8'hCF);
        pla_oe = 8'h00;
        @(negedge clk);
        chk_pins("R6 addr-out fixed drive", 8'hE6, 8'h0F, 8'hA5, 8'h0F);

        // peripheral override
        periph_en = 1; periph_out = 8'h5C; periph_oe = 8'hF3;
        @(negedge clk);
        chk_pins("R8 periph", 8'h5C, 8'hF3, 8'h5C, 8'hF3);

        // test-access release
        jtag_en = 1;
        @(negedge clk);
        chk_pins("R9 jtag over periph", 8'h0C, 8'h03, 8'h0C, 8'h03);
        periph_en = 0;
        @(negedge clk);
        chk_pins("R9 jtag over modes", 8'h06, 8'h0F, 8'h05, 8'h0F);
        jtag_en = 0;
        @(negedge clk);
        chk_pins("R9 released back", 8'hE6, 8'h0F, 8'hA5, 8'h0F);

        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule